// File: doc/BRIEF.md
# Sizable Memory Window Register

This block holds the base address of one memory window that an endpoint exposes to the system. Software reaches it through a small configuration port that writes and reads 32-bit words. Word 0 holds the low part of the base together with read-only flag bits. Word 1 holds the upper 32 address bits when the window is built with a 64-bit decoder. The window size is a compile-time power of two. Every address bit below that size reads as zero and ignores writes. Software therefore finds the size by writing all ones and reading the word back, and any base it programs is naturally aligned.

Memory requests arrive with a 64-bit address. When decoding is enabled and the address falls inside the programmed window, the block raises a hit flag and presents the address bits below the window size as an offset into the local buffer. Parameters select the space flag and the prefetchable flag. These two flags only change the value read back.

Top module: `mem_window_reg`

## Requirements
- R1: After reset, word 0 reads as the flag bits with a zero base, and word 1 reads as zero.
- R2: Word 0 bits [3:0] are read-only flags: bit 0 = IO_SPACE parameter (0 memory), bits [2:1] = 2'b00 for a 32-bit decoder or 2'b10 for a 64-bit decoder, bit 3 = PREFETCH parameter; writes leave them unchanged.
- R3: Word 0 bits [SIZE_LOG2-1:4] always read zero, so writing 0xFFFFFFFF reads back the size mask ORed with the flags (a 1 MB 32-bit non-prefetchable memory window reads 0xFFF00000).
- R4: Word 0 bits [31:SIZE_LOG2] read back the value last written to them.
- R5: With a 64-bit decoder, word 1 is fully writable and reads back the last written value; with a 32-bit decoder, word 1 reads zero and writes to it have no effect.
- R6: hit is high when req_valid and mem_en are both high and req_addr[63:SIZE_LOG2] equals the base bits [63:SIZE_LOG2]; with a 32-bit decoder the base upper half is zero, so addresses at or above 4 GB never hit.
- R7: hit is low whenever mem_en or req_valid is low, whatever the address.
- R8: hit_offset equals req_addr[SIZE_LOG2-1:0] whenever hit is high.
- R9: A request in the same cycle as a configuration write is decoded against the base held before that write; the new base applies from the next cycle.
- R10: cfg_rdata is combinational and shows word 0 when cfg_idx is 0 and word 1 when cfg_idx is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 1 | Word select: 0 low word, 1 upper word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for the selected word |
| mem_en | input | 1 | Memory decode enable |
| req_valid | input | 1 | Incoming memory request valid |
| req_addr | input | 64 | Incoming memory request address |
| hit | output | 1 | Request falls inside the window |
| hit_offset | output | SIZE_LOG2 | Offset into the local buffer |

## Verification
Reprogramming the base and decoding a request can happen in the same cycle. The bench creates this case by holding a request at an address inside the new window while it writes that new base. Before the write edge it expects a miss, because the old base still applies. After the edge it expects a hit with the matching offset. Around this case, the bench sweeps addresses across the window edges for a 64-bit and a 32-bit instance and computes each hit and offset from the programmed base.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned FLAG_W = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // Read-only flag nibble of the low word.
  function automatic word_t flag_bits(input bit io_space, input bit is64, input bit pref);
    word_t f;
    f = '0;
    f[0] = io_space;
    f[2:1] = is64 ? 2'b10 : 2'b00;
    f[3] = pref;
    return f;
  endfunction

  // Bits at or above the window size are set.
  function automatic word_t size_mask(input int unsigned size_log2);
    return ~((word_t'(1) << size_log2) - word_t'(1));
  endfunction

  // Bits strictly between the flags and the window size are set.
  function automatic word_t hard_zero_mask(input int unsigned size_log2);
    return ~size_mask(size_log2) & ~word_t'((1 << FLAG_W) - 1);
  endfunction

endpackage

// File: rtl/mwr_lo_reg.sv
module mwr_lo_reg
  import mwr_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 12,
  parameter word_t       FLAGS     = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [WORD_W-1:SIZE_LOG2] wr_field,
  output word_t                 rdata,
  output word_t                 base_lo
);
  localparam int unsigned FIELD_W = WORD_W - SIZE_LOG2;

  logic [FIELD_W-1:0] field_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     field_q <= '0;
    else if (wr_en) field_q <= wr_field;
  end

  assign base_lo = {field_q, {SIZE_LOG2{1'b0}}};
  assign rdata   = base_lo | FLAGS;

  p_base_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[WORD_W-1:SIZE_LOG2] == $past(wr_field)));

  p_base_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(base_lo));

endmodule

// File: rtl/mwr_hi_reg.sv
module mwr_hi_reg
  import mwr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wdata,
  output word_t base_hi
);
  word_t hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_q <= '0;
    else if (wr_en) hi_q <= wdata;
  end

  assign base_hi = hi_q;

  p_hi_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (base_hi == $past(wdata)));

endmodule

// File: rtl/mwr_decode.sv
module mwr_decode
  import mwr_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  addr_t                base,
  input  logic                 mem_en,
  input  logic                 req_valid,
  input  addr_t                req_addr,
  output logic                 hit,
  output logic [SIZE_LOG2-1:0] hit_offset
);
  logic page_eq;
  logic req_live;

  assign page_eq    = (req_addr[ADDR_W-1:SIZE_LOG2] == base[ADDR_W-1:SIZE_LOG2]);
  assign req_live   = req_valid & mem_en;
  assign hit        = req_live & page_eq;
  assign hit_offset = req_addr[SIZE_LOG2-1:0];

  p_no_hit_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_en || !req_valid) |-> !hit);

  p_hit_in_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((req_addr - base) < (addr_t'(1) << SIZE_LOG2)));

endmodule

// File: rtl/mem_window_reg.sv
module mem_window_reg
  import mwr_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 12,
  parameter bit          IS_64     = 1'b1,
  parameter bit          PREFETCH  = 1'b0,
  parameter bit          IO_SPACE  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_idx,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 mem_en,
  input  logic                 req_valid,
  input  logic [63:0]          req_addr,
  output logic                 hit,
  output logic [SIZE_LOG2-1:0] hit_offset
);
  localparam word_t FLAGS    = flag_bits(IO_SPACE, IS_64, PREFETCH);
  localparam word_t ZERO_MSK = hard_zero_mask(SIZE_LOG2);

  word_t lo_rdata;
  word_t base_lo;
  word_t base_hi;
  addr_t base;
  logic  lo_wr;
  logic  hi_wr;

  assign lo_wr = cfg_wr & ~cfg_idx;
  assign hi_wr = cfg_wr &  cfg_idx;

  mwr_lo_reg #(.SIZE_LOG2(SIZE_LOG2), .FLAGS(FLAGS)) u_lo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (lo_wr),
    .wr_field (cfg_wdata[WORD_W-1:SIZE_LOG2]),
    .rdata    (lo_rdata),
    .base_lo  (base_lo)
  );

  generate
    if (IS_64) begin : g_hi
      mwr_hi_reg u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hi_wr),
        .wdata   (cfg_wdata),
        .base_hi (base_hi)
      );
    end else begin : g_nohi
      assign base_hi = '0;
    end
  endgenerate

  assign base      = {base_hi, base_lo};
  assign cfg_rdata = cfg_idx ? base_hi : lo_rdata;

  mwr_decode #(.SIZE_LOG2(SIZE_LOG2)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .base       (base),
    .mem_en     (mem_en),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .hit        (hit),
    .hit_offset (hit_offset)
  );

  p_size_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_idx |-> ((cfg_rdata & ZERO_MSK) == '0));

  p_flags_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_idx && $past(!cfg_idx)) |-> (cfg_rdata[3:0] == $past(cfg_rdata[3:0])));

  p_hit_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!cfg_wr) && $stable(req_addr) && $stable(req_valid) && $stable(mem_en))
      |-> $stable(hit));

endmodule

// File: tb/sim_mem_window_reg.sv
module sim_mem_window_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_idx = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;

  logic [31:0] rd0, rd1;
  logic        hit0, hit1;
  logic [11:0] off0;
  logic [19:0] off1;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  // u0: 64-bit decoder, 4 KB, prefetchable. u1: 32-bit decoder, 1 MB.
  mem_window_reg #(.SIZE_LOG2(12), .IS_64(1'b1), .PREFETCH(1'b1), .IO_SPACE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd0), .mem_en(mem_en), .req_valid(req_valid), .req_addr(req_addr),
    .hit(hit0), .hit_offset(off0));

  mem_window_reg #(.SIZE_LOG2(20), .IS_64(1'b0), .PREFETCH(1'b0), .IO_SPACE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd1), .mem_en(mem_en), .req_valid(req_valid), .req_addr(req_addr),
    .hit(hit1), .hit_offset(off1));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic idx, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic read_both(input logic idx, output logic [31:0] a, output logic [31:0] b);
    @(negedge clk);
    cfg_idx = idx;
    #1;
    a = rd0; b = rd1;
  endtask

  task automatic probe(input logic [63:0] addr, input logic en, input logic vld);
    @(negedge clk);
    req_addr = addr; mem_en = en; req_valid = vld;
    #1;
  endtask

  // Bench model of the programmed bases.
  logic [63:0] b0_model;
  logic [63:0] b1_model;

  task automatic sweep_check(input logic [63:0] addr);
    bit e0, e1;
    probe(addr, 1'b1, 1'b1);
    e0 = ((addr >> 12) == (b0_model >> 12));
    e1 = ((addr >> 20) == (b1_model >> 20));
    check(hit0 == e0, "R6 u0 hit", 64'(hit0), 64'(e0));
    check(hit1 == e1, "R6 u1 hit", 64'(hit1), 64'(e1));
    if (e0) check(off0 == addr[11:0], "R8 u0 offset", 64'(off0), 64'(addr[11:0]));
    if (e1) check(off1 == addr[19:0], "R8 u1 offset", 64'(off1), 64'(addr[19:0]));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] a, b;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R2 / R10: reset values, flag nibble 0xC for u0, 0x0 for u1
    read_both(1'b0, a, b);
    check(a == 32'h0000_000C, "R1 u0 word0", 64'(a), 64'h0000_000C);
    check(b == 32'h0000_0000, "R1 u1 word0", 64'(b), 64'h0);
    read_both(1'b1, a, b);
    check(a == 32'h0, "R1 u0 word1", 64'(a), 64'h0);
    check(b == 32'h0, "R1 u1 word1", 64'(b), 64'h0);

    // R3 size probe; R2 flags unchanged by write
    cfg_write(1'b0, 32'hFFFF_FFFF);
    read_both(1'b0, a, b);
    check(a == 32'hFFFF_F00C, "R3 u0 probe", 64'(a), 64'hFFFF_F00C);
    check(b == 32'hFFF0_0000, "R3 u1 probe", 64'(b), 64'hFFF0_0000);
    check(a[3:0] == 4'hC, "R2 u0 flags after write", 64'(a[3:0]), 64'hC);

    // R5 upper word
    cfg_write(1'b1, 32'hFFFF_FFFF);
    read_both(1'b1, a, b);
    check(a == 32'hFFFF_FFFF, "R5 u0 word1 probe", 64'(a), 64'hFFFF_FFFF);
    check(b == 32'h0, "R5 u1 word1 ignored", 64'(b), 64'h0);

    // R4 program a base; low bits dropped
    cfg_write(1'b0, 32'hABCD_E123);
    cfg_write(1'b1, 32'h0000_0007);
    read_both(1'b0, a, b);
    check(a == 32'hABCD_E00C, "R4 u0 word0", 64'(a), 64'hABCD_E00C);
    check(b == 32'hABC0_0000, "R4 u1 word0", 64'(b), 64'hABC0_0000);
    read_both(1'b1, a, b);
    check(a == 32'h7, "R5 u0 word1", 64'(a), 64'h7);
    check(b == 32'h0, "R5 u1 word1", 64'(b), 64'h0);
    b0_model = {32'h7, 32'hABCD_E123 & ~32'hFFF};
    b1_model = {32'h0, 32'hABCD_E123 & ~32'hF_FFFF};

    // R6/R8 sweep around the u0 window (upper half 7, u1 never hits)
    for (int k = 0; k < 64; k++)
      sweep_check(b0_model - 64'd8192 + 64'(k) * 64'd331);
    // R6 boundaries for u0
    sweep_check(b0_model - 1);
    sweep_check(b0_model);
    sweep_check(b0_model + 64'hFFF);
    sweep_check(b0_model + 64'h1000);
    // R6 sweep around the u1 window (32-bit space)
    for (int k = 0; k < 64; k++)
      sweep_check(b1_model - 64'h20_0000 + 64'(k) * 64'h1_3579);
    sweep_check(b1_model + 64'hF_FFFF);
    sweep_check(b1_model + 64'h10_0000);
    // R6: u1 misses above 4 GB even with matching low bits
    sweep_check(b1_model | 64'h1_0000_0000);

    // R7 disabled decode
    probe(b0_model + 5, 1'b0, 1'b1);
    check(hit0 == 1'b0, "R7 u0 mem_en low", 64'(hit0), 64'h0);
    probe(b1_model + 5, 1'b1, 1'b0);
    check(hit1 == 1'b0, "R7 u1 req_valid low", 64'(hit1), 64'h0);

    // R9 write and request in the same cycle
    probe(64'h0000_0000_5550_0abc, 1'b1, 1'b1);
    check(hit1 == 1'b0, "R9 u1 before write", 64'(hit1), 64'h0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 1'b0; cfg_wdata = 32'h5550_0000;
    #1;
    check(hit1 == 1'b0, "R9 u1 old base in write cycle", 64'(hit1), 64'h0);
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
    check(hit1 == 1'b1, "R9 u1 new base next cycle", 64'(hit1), 64'h1);
    check(off1 == 20'h00abc, "R8 u1 offset after write", 64'(off1), 64'h00abc);
    b0_model = {32'h7, 32'h5550_0000};
    b1_model = 64'h5550_0000;
    sweep_check(64'h7_5550_0ff0);
    sweep_check(64'h0_5550_0ff0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule